// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of a single SDRAM read or write burst. A controller pulses a start strobe together with a start column, a burst length code and an ordering bit. From the next clock on, the generator presents one column address per cycle with a valid flag, and flags the final beat of a fixed-length burst with a last marker.

Two orderings are supported. In wrap-around (sequential) order the low bits of the column count up modulo the burst length while the upper bits stay put. In exclusive-or (interleaved) order the beat index is XORed into the low bits. A full-page setting keeps incrementing the whole column, wrapping at the top of the row, until the controller ends it. A burst can be cut short by a stop request, or restarted mid-way by an interrupting column command, unless the burst was launched with auto precharge. In that case interrupting commands are ignored.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and while no burst is running, `valid_o` and `last_o` are 0.
- R2: A `start_i` pulse while idle starts a burst: in the next cycle `valid_o` is 1 and `col_o` equals `start_col_i`, and one new column follows every cycle. A `start_i` pulse during a running burst is ignored.
- R3: `blen_code_i` selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The reserved codes 3'b100, 3'b101 and 3'b110 act as length 1. A fixed-length burst of length BL delivers exactly BL valid beats.
- R4: With `btype_i` = 0 (sequential), beat k carries the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. The upper bits are unchanged.
- R5: With `btype_i` = 1 (interleaved), beat k carries the start column XOR k, for k from 0 to BL-1.
- R6: In full-page mode, beat k carries (start column + k) mod 256, and the burst runs until a stop or interrupt ends it. `btype_i` has no effect in this mode.
- R7: `last_o` is 1 exactly on the final beat of a fixed-length burst. `valid_o` drops in the cycle after it. `last_o` is never 1 in full-page mode.
- R8: `stop_i` high in a valid cycle makes that beat the final one, for every burst length. `valid_o` is 0 in the next cycle.
- R9: `intr_i` high in a valid cycle of a burst without auto precharge restarts the burst. In the next cycle `col_o` equals `intr_col_i`, and the ordering restarts from beat 0 with the same length and ordering. `intr_i` takes priority over `stop_i` in the same cycle.
- R10: `autopre_i` is captured with `start_i`. When it is set, `intr_i` is ignored for the whole burst and the column sequence continues unchanged. `stop_i` is still honoured.
- R11: `stop_i` and `intr_i` have no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst (honoured while idle) |
| start_col_i | input | COL_W | First column of the burst |
| blen_code_i | input | 3 | Burst length code |
| btype_i | input | 1 | 0 = sequential, 1 = interleaved |
| autopre_i | input | 1 | Burst uses auto precharge (locks out interrupts) |
| stop_i | input | 1 | End the burst after the current beat |
| intr_i | input | 1 | Restart the burst from a new column |
| intr_col_i | input | COL_W | New start column for an interrupt |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench uses the default COL_W of 8, so a full page is 256 columns. A run of 260 beats from column 0xF0 crosses the row wrap at 0xFF to 0x00. Start columns are chosen with nonzero bits both inside and above the length field. This exposes mistakes in the sequential wrap and in the XOR ordering at lengths 2, 4 and 8. The 8-bit column also lets the bench compute expected addresses by plain modular arithmetic, with no copy of the design's per-bit logic.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic   page;   // full-page burst, no last beat
        order_e order;  // address ordering
        logic   locked; // auto precharge: interrupts refused
    } burst_mode_t;

    // number of low column bits covered by a fixed burst length code
    function automatic int field_bits(input logic [CODE_W-1:0] code);
        case (code)
            LEN_TWO:   return 1;
            LEN_FOUR:  return 2;
            LEN_EIGHT: return 3;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              page_o
);
    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    int nbits;

    always_comb begin
        nbits  = field_bits(code_i);
        page_o = (code_i == LEN_PAGE);
        mask_o = '0;
        if (page_o) begin
            mask_o = ALL_ONES;
        end else begin
            for (int b = 0; b < COL_W; b++) begin
                mask_o[b] = (b < nbits);
            end
        end
    end
endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    assign sum = base_i + beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        logic seq_bit;
        logic xor_bit;
        assign seq_bit  = mask_i[i] ? sum[i] : base_i[i];
        assign xor_bit  = base_i[i] ^ (beat_i[i] & mask_i[i]);
        assign col_o[i] = (order_i == ORD_XOR) ? xor_bit : seq_bit;
    end

    // bits above the burst field never move (R4, R5)
    always_comb begin
        p_upper_fixed_r4: assert ((col_o & ~mask_i) == (base_i & ~mask_i))
            else $error("column left its burst field");
    end
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] dec_mask_i,
    input  logic             dec_page_i,
    input  logic             btype_i,
    input  logic             autopre_i,
    input  logic             stop_i,
    input  logic             intr_i,
    input  logic [COL_W-1:0] intr_col_i,
    output logic             active_o,
    output logic             final_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output burst_mode_t      mode_o
);
    logic             active_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    burst_mode_t      mode_q;

    logic start_ok;
    logic restart;
    logic at_end;
    logic finish;

    assign start_ok = start_i & ~active_q;
    assign restart  = active_q & intr_i & ~mode_q.locked;
    assign at_end   = active_q & ~mode_q.page & (beat_q == mask_q);
    assign finish   = active_q & (stop_i | at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            beat_q   <= '0;
            mask_q   <= '0;
            mode_q   <= '0;
        end else if (start_ok) begin
            active_q      <= 1'b1;
            base_q        <= start_col_i;
            beat_q        <= '0;
            mask_q        <= dec_mask_i;
            mode_q.page   <= dec_page_i;
            mode_q.order  <= (dec_page_i || !btype_i) ? ORD_SEQ : ORD_XOR;
            mode_q.locked <= autopre_i;
        end else if (restart) begin
            base_q <= intr_col_i;
            beat_q <= '0;
        end else if (finish) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (active_q) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign active_o = active_q;
    assign final_o  = at_end;
    assign base_o   = base_q;
    assign beat_o   = beat_q;
    assign mask_o   = mask_q;
    assign mode_o   = mode_q;

    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!active_q && start_i) |=> (active_q && beat_q == '0))
        else $error("idle start did not open a burst");

    p_last_closes_r7: assert property (@(posedge clk) disable iff (rst)
        (at_end && !(intr_i && !mode_q.locked)) |=> !active_q)
        else $error("burst continued past its final beat");

    p_stop_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (active_q && stop_i && !(intr_i && !mode_q.locked)) |=> !active_q)
        else $error("stop request not honoured");

    p_intr_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (active_q && intr_i && !mode_q.locked)
        |=> (active_q && beat_q == '0 && base_q == $past(intr_col_i)))
        else $error("interrupt did not restart the burst");

    p_lock_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q.locked && intr_i && !stop_i && !at_end)
        |=> (active_q && $stable(base_q)))
        else $error("locked burst accepted an interrupt");

    p_page_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q.page && !stop_i && !intr_i)
        |=> (active_q && beat_q == COL_W'($past(beat_q) + 1'b1)))
        else $error("full-page burst did not advance");

    p_page_nolast_r7: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q.page) |-> !at_end)
        else $error("last flagged in full-page burst");
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] blen_code_i,
    input  logic              btype_i,
    input  logic              autopre_i,
    input  logic              stop_i,
    input  logic              intr_i,
    input  logic [COL_W-1:0]  intr_col_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    burst_mode_t      mode;
    logic             active;
    logic             fin;

    colgen_len_dec #(.COL_W(COL_W)) u_dec (
        .code_i (blen_code_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .dec_mask_i  (dec_mask),
        .dec_page_i  (dec_page),
        .btype_i     (btype_i),
        .autopre_i   (autopre_i),
        .stop_i      (stop_i),
        .intr_i      (intr_i),
        .intr_col_i  (intr_col_i),
        .active_o    (active),
        .final_o     (fin),
        .base_o      (base),
        .beat_o      (beat),
        .mask_o      (mask),
        .mode_o      (mode)
    );

    colgen_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i  (base),
        .beat_i  (beat),
        .mask_i  (mask),
        .order_i (mode.order),
        .col_o   (col_o)
    );

    assign valid_o = active;
    assign last_o  = fin;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> !last_o)
        else $error("last without valid");
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_code_i = '0;
    logic             btype_i = 1'b0;
    logic             autopre_i = 1'b0;
    logic             stop_i = 1'b0;
    logic             intr_i = 1'b0;
    logic [COL_W-1:0] intr_col_i = '0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .blen_code_i(blen_code_i), .btype_i(btype_i), .autopre_i(autopre_i),
        .stop_i(stop_i), .intr_i(intr_i), .intr_col_i(intr_col_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int base, input int k, input int bl, input bit ilv);
        int lowb;
        if (ilv) return base ^ k;
        lowb = base % bl;
        return base - lowb + ((lowb + k) % bl);
    endfunction

    task automatic launch(input int base, input logic [2:0] code, input bit ty, input bit ap);
        @(negedge clk);
        start_i     = 1'b1;
        start_col_i = COL_W'(base);
        blen_code_i = code;
        btype_i     = ty;
        autopre_i   = ap;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_beat(input string req, input int exp, input bit exp_last);
        chk(valid_o == 1'b1, req, valid_o, 1);
        chk(col_o == COL_W'(exp), req, col_o, exp);
        chk(last_o == exp_last, req, last_o, exp_last);
    endtask

    task automatic check_idle(input string req);
        chk(valid_o == 1'b0, req, valid_o, 0);
        chk(last_o == 1'b0, req, last_o, 0);
    endtask

    // R3 R4 R5 R7: full fixed-length burst
    task automatic t_fixed(input int base, input logic [2:0] code, input int bl, input bit ty);
        launch(base, code, ty, 1'b0);
        for (int k = 0; k < bl; k++) begin
            check_beat(ty ? "R5 interleave beat" : "R4 sequential beat",
                       exp_col(base, k, bl, ty), k == bl - 1);
            @(negedge clk);
        end
        check_idle("R3 R7 burst ends after BL beats");
    endtask

    // R6: full page wraps through the row, then stop ends it
    task automatic t_page();
        launch(8'hF0, 3'b111, 1'b1, 1'b0);
        for (int k = 0; k < 260; k++) begin
            check_beat("R6 full page column", (8'hF0 + k) % 256, 1'b0);
            if (k == 259) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        check_idle("R6 R8 full page stopped");
    endtask

    // R8: stop mid fixed burst
    task automatic t_stop();
        launch(8'h1D, 3'b011, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            check_beat("R8 beat before stop", exp_col(8'h1D, k, 8, 1'b0), 1'b0);
            if (k == 2) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        check_idle("R8 stop ends burst");
    endtask

    // R9: interrupt restarts, and wins over a simultaneous stop
    task automatic t_intr();
        launch(8'h35, 3'b010, 1'b1, 1'b0);
        check_beat("R9 first burst beat0", 8'h35, 1'b0);
        @(negedge clk);
        check_beat("R9 first burst beat1", 8'h34, 1'b0);
        intr_i = 1'b1; intr_col_i = 8'h62; stop_i = 1'b1;
        @(negedge clk);
        intr_i = 1'b0; stop_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check_beat("R9 restarted beat", 8'h62 ^ k, k == 3);
            @(negedge clk);
        end
        check_idle("R9 restarted burst ends");
    endtask

    // R10: locked burst ignores interrupt
    task automatic t_locked();
        launch(8'h42, 3'b010, 1'b0, 1'b1);
        check_beat("R10 beat0", 8'h42, 1'b0);
        intr_i = 1'b1; intr_col_i = 8'hC8;
        @(negedge clk);
        intr_i = 1'b0;
        check_beat("R10 beat1 unchanged", 8'h43, 1'b0);
        @(negedge clk);
        check_beat("R10 beat2 unchanged", 8'h40, 1'b0);
        @(negedge clk);
        check_beat("R10 beat3 last", 8'h41, 1'b1);
        @(negedge clk);
        check_idle("R10 locked burst ends");
    endtask

    // R2: start during a running burst is ignored
    task automatic t_start_busy();
        launch(8'h09, 3'b001, 1'b0, 1'b0);
        check_beat("R2 beat0", 8'h09, 1'b0);
        start_i = 1'b1; start_col_i = 8'hAA;
        @(negedge clk);
        start_i = 1'b0;
        check_beat("R2 busy start ignored", 8'h08, 1'b1);
        @(negedge clk);
        check_idle("R2 burst ends normally");
    endtask

    // R11: stop / interrupt while idle do nothing
    task automatic t_idle_ignore();
        @(negedge clk);
        stop_i = 1'b1; intr_i = 1'b1; intr_col_i = 8'h5A;
        @(negedge clk);
        stop_i = 1'b0; intr_i = 1'b0;
        check_idle("R11 idle stop/intr");
        @(negedge clk);
        check_idle("R11 still idle");
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1 reset state");
        t_fixed(8'h77, 3'b000, 1, 1'b0);   // R3 length 1
        t_fixed(8'h77, 3'b101, 1, 1'b0);   // R3 reserved code -> 1
        t_fixed(8'h5B, 3'b001, 2, 1'b0);
        t_fixed(8'h5B, 3'b010, 4, 1'b0);
        t_fixed(8'h5B, 3'b011, 8, 1'b0);
        t_fixed(8'hA6, 3'b001, 2, 1'b1);
        t_fixed(8'hA6, 3'b010, 4, 1'b1);
        t_fixed(8'hA6, 3'b011, 8, 1'b1);
        t_page();
        t_stop();
        t_intr();
        t_locked();
        t_start_busy();
        t_idle_ignore();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule